// File: doc/BRIEF.md
# Virtual Address Translation and Access Permission Checker

This block sits between a processor's load/store/fetch path and its translation buffer. For each request it takes a 32-bit virtual address, the direction of the access (read or write), whether the access is an instruction fetch, and whether the processor is running privileged. It returns either a physical address or an exception code, one clock cycle later.

Two cases skip translation: fixed, untranslated address regions, and any request made while translation is switched off. For these the physical address is the virtual address with its top three bits cleared. Unprivileged code may reach the untranslated regions only through a small window at the bottom of the top region. Any other unprivileged access there is reported as a buffer miss.

For translated addresses the block does not search the buffer. It takes the result of the lookup (hit, multiple hit, page number, page size, protection and dirty bit) and from these it checks the access rights and builds the physical address. It also tells the lookup logic whether address-space identifiers must be compared.

Top module: `mmu_xlate_chk`

## Requirements
- R1: An address in 0x80000000..0xBFFFFFFF, or at or above 0xE0000000, is an untranslated region. A privileged access there gives pa_ok_o=1, exc_code_o=0 and paddr_o = vaddr_i with bits 31:29 cleared, whatever mmu_en_i and the buffer inputs are.
- R2: An unprivileged access to an untranslated region outside 0xE0000000..0xE4000000 (both ends included) gives exc_code_o 0x060 if it is a write, else 0x040, and pa_ok_o=0. An unprivileged access inside that window behaves as in R1.
- R3: With mmu_en_i=0, an address outside the untranslated regions gives pa_ok_o=1, exc_code_o=0 and paddr_o = vaddr_i with bits 31:29 cleared, for any privilege and direction.
- R4: use_asid_o is 1 exactly when single_vm_i=0 and priv_i=0. It is combinational.
- R5: On a translated access with tlb_multi_i=1, exc_code_o is 0x140. This takes precedence over every other buffer input.
- R6: On a translated access with tlb_hit_i=0 and tlb_multi_i=0, exc_code_o is 0x060 for a write, else 0x040. A fetch counts as a read here.
- R7: An access is a fetch when fetch_i=1 and write_i=0. A fetch that hits faults with 0x0A0 when priv_i=1 and tlb_prot_i[1]=0, and succeeds otherwise. Neither the data rules nor the dirty bit apply to a fetch.
- R8: For a data access that hits, the protection rules are as follows. An unprivileged access with tlb_prot_i[1]=0 faults on both reads and writes. A write with tlb_prot_i[0]=0 faults. So prot 3 allows everything, and prot 1 allows everything in privileged mode. A write fault gives 0x0C0 and a read fault gives 0x0A0.
- R9: A data write that passes R8 to a page with tlb_dirty_i=0 gives exc_code_o 0x080.
- R10: A successful translated access gives paddr_o = ({tlb_ppn_i,10'b0} & ~M) | (vaddr_i & M). M is the mask for tlb_size_i: 0 gives 0x3FF (1 KB), 1 gives 0xFFF (4 KB), 2 gives 0xFFFF (64 KB) and 3 gives 0xFFFFF (1 MB).
- R11: The response is registered. rsp_valid_o is 1 in the cycle after req_valid_i=1. A nonzero exc_code_o forces pa_ok_o to 0, and 0 means no exception. After reset rsp_valid_o, pa_ok_o and exc_code_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| vaddr_i | input | 32 | Virtual address |
| write_i | input | 1 | 1 for a write, 0 for a read |
| fetch_i | input | 1 | Instruction fetch |
| priv_i | input | 1 | Privileged mode |
| mmu_en_i | input | 1 | Translation enable |
| single_vm_i | input | 1 | Single virtual memory mode (no ASID compare) |
| tlb_hit_i | input | 1 | Lookup found exactly one entry |
| tlb_multi_i | input | 1 | Lookup found more than one entry |
| tlb_ppn_i | input | 22 | Physical page number of the hit entry (address bits 31:10) |
| tlb_size_i | input | 2 | Page size code of the hit entry |
| tlb_prot_i | input | 2 | Protection code of the hit entry |
| tlb_dirty_i | input | 1 | Dirty bit of the hit entry |
| use_asid_o | output | 1 | Lookup must compare address-space identifiers |
| rsp_valid_o | output | 1 | Response present this cycle |
| paddr_o | output | 32 | Physical address |
| exc_code_o | output | 12 | Exception code, 0 for none |
| pa_ok_o | output | 1 | Physical address usable |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- that an exception always clears pa_ok_o;
- the masked pass-through for privileged untranslated accesses;
- the multiple-hit code;
- the unprivileged protection fault.

The bench sweeps a grid of boundary addresses against every combination of direction, fetch, privilege, enable, protection, dirty bit, hit kind and page size. Only that sweep shows the edges of the user window, the precedence among faults, and the exact physical address for each page size. It also shows the dirty-bit fault and the ASID request output.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;
  localparam int VA_W  = 32;
  localparam int PG_SH = 10;
  localparam int PPN_W = VA_W - PG_SH;
  localparam int EXC_W = 12;
  localparam int SZ_N  = 4;

  localparam logic [EXC_W-1:0] EXC_NONE    = 12'h000;
  localparam logic [EXC_W-1:0] EXC_RD_MISS = 12'h040;
  localparam logic [EXC_W-1:0] EXC_WR_MISS = 12'h060;
  localparam logic [EXC_W-1:0] EXC_INIT_WR = 12'h080;
  localparam logic [EXC_W-1:0] EXC_RD_PROT = 12'h0A0;
  localparam logic [EXC_W-1:0] EXC_WR_PROT = 12'h0C0;
  localparam logic [EXC_W-1:0] EXC_MULTI   = 12'h140;

  localparam logic [VA_W-1:0] FIX_LO_BASE = 32'h8000_0000;
  localparam logic [VA_W-1:0] FIX_LO_END  = 32'hC000_0000;
  localparam logic [VA_W-1:0] FIX_HI_BASE = 32'hE000_0000;
  localparam logic [VA_W-1:0] WIN_LAST    = 32'hE400_0000;

  typedef enum logic [1:0] {SZ_1K = 2'd0, SZ_4K = 2'd1, SZ_64K = 2'd2, SZ_1M = 2'd3} pg_size_e;

  function automatic int size_shift(input int code);
    case (code)
      0: return 10;
      1: return 12;
      2: return 16;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/mmu_region_dec.sv
module mmu_region_dec
  import mmu_chk_pkg::*;
(
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            priv_i,
  output logic            fixed_o,
  output logic            user_ok_o
);
  logic in_lo, in_hi, in_win;

  assign in_lo     = (vaddr_i >= FIX_LO_BASE) && (vaddr_i < FIX_LO_END);
  assign in_hi     = (vaddr_i >= FIX_HI_BASE);
  assign in_win    = in_hi && (vaddr_i <= WIN_LAST);
  assign fixed_o   = in_lo || in_hi;
  assign user_ok_o = priv_i || in_win;
endmodule

// File: rtl/mmu_perm_chk.sv
module mmu_perm_chk
  import mmu_chk_pkg::*;
(
  input  logic             is_fetch_i,
  input  logic             write_i,
  input  logic             priv_i,
  input  logic [1:0]       prot_i,
  input  logic             dirty_i,
  output logic [EXC_W-1:0] exc_o
);
  always_comb begin
    exc_o = EXC_NONE;
    if (is_fetch_i) begin
      if (priv_i && !prot_i[1]) exc_o = EXC_RD_PROT;
    end else if (!priv_i && !prot_i[1]) begin
      exc_o = write_i ? EXC_WR_PROT : EXC_RD_PROT;
    end else if (write_i && !prot_i[0]) begin
      exc_o = EXC_WR_PROT;
    end else if (write_i && !dirty_i) begin
      exc_o = EXC_INIT_WR;
    end
  end
endmodule

// File: rtl/mmu_pa_build.sv
module mmu_pa_build
  import mmu_chk_pkg::*;
(
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [1:0]       size_i,
  output logic [VA_W-1:0]  paddr_o
);
  logic [VA_W-1:0] mask_tbl [SZ_N];
  logic [VA_W-1:0] mask;

  for (genvar g = 0; g < SZ_N; g++) begin : g_mask
    localparam int SH = size_shift(g);
    assign mask_tbl[g] = (VA_W'(1) << SH) - VA_W'(1);
  end

  assign mask    = mask_tbl[size_i];
  assign paddr_o = ({ppn_i, {PG_SH{1'b0}}} & ~mask) | (vaddr_i & mask);
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk
  import mmu_chk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [31:0]      vaddr_i,
  input  logic             write_i,
  input  logic             fetch_i,
  input  logic             priv_i,
  input  logic             mmu_en_i,
  input  logic             single_vm_i,
  input  logic             tlb_hit_i,
  input  logic             tlb_multi_i,
  input  logic [21:0]      tlb_ppn_i,
  input  logic [1:0]       tlb_size_i,
  input  logic [1:0]       tlb_prot_i,
  input  logic             tlb_dirty_i,
  output logic             use_asid_o,
  output logic             rsp_valid_o,
  output logic [31:0]      paddr_o,
  output logic [11:0]      exc_code_o,
  output logic             pa_ok_o
);
  logic             fixed, user_ok, is_fetch, mapped;
  logic [EXC_W-1:0] perm_exc, exc_d;
  logic [VA_W-1:0]  pa_map, pa_flat, pa_d;
  logic             started_q;

  assign use_asid_o = !single_vm_i && !priv_i;
  assign is_fetch   = fetch_i && !write_i;
  assign mapped     = !fixed && mmu_en_i;
  assign pa_flat    = {3'b000, vaddr_i[VA_W-4:0]};

  mmu_region_dec u_region (
    .vaddr_i  (vaddr_i),
    .priv_i   (priv_i),
    .fixed_o  (fixed),
    .user_ok_o(user_ok)
  );

  mmu_perm_chk u_perm (
    .is_fetch_i(is_fetch),
    .write_i   (write_i),
    .priv_i    (priv_i),
    .prot_i    (tlb_prot_i),
    .dirty_i   (tlb_dirty_i),
    .exc_o     (perm_exc)
  );

  mmu_pa_build u_pa (
    .vaddr_i(vaddr_i),
    .ppn_i  (tlb_ppn_i),
    .size_i (tlb_size_i),
    .paddr_o(pa_map)
  );

  always_comb begin
    exc_d = EXC_NONE;
    pa_d  = pa_flat;
    if (fixed) begin
      if (!user_ok) exc_d = write_i ? EXC_WR_MISS : EXC_RD_MISS;
    end else if (mmu_en_i) begin
      pa_d = pa_map;
      if (tlb_multi_i)     exc_d = EXC_MULTI;
      else if (!tlb_hit_i) exc_d = write_i ? EXC_WR_MISS : EXC_RD_MISS;
      else                 exc_d = perm_exc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      paddr_o     <= '0;
      exc_code_o  <= EXC_NONE;
      pa_ok_o     <= 1'b0;
      started_q   <= 1'b0;
    end else begin
      started_q   <= 1'b1;
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        paddr_o    <= pa_d;
        exc_code_o <= exc_d;
        pa_ok_o    <= (exc_d == EXC_NONE);
      end
    end
  end

  assert_rsp_timing_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (rsp_valid_o == $past(req_valid_i)));

  assert_exc_blocks_ok_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && exc_code_o != EXC_NONE) |-> !pa_ok_o);

  assert_fixed_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && fixed && priv_i) |=>
      (pa_ok_o && paddr_o == {3'b000, $past(vaddr_i[28:0])}));

  assert_multi_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mapped && tlb_multi_i) |=> (exc_code_o == EXC_MULTI));

  assert_user_prot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mapped && tlb_hit_i && !tlb_multi_i && !is_fetch &&
     !priv_i && !tlb_prot_i[1]) |=>
      (exc_code_o == ($past(write_i) ? EXC_WR_PROT : EXC_RD_PROT)));
endmodule

// File: tb/mmu_xlate_chk_test.sv
module mmu_xlate_chk_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic        write = 1'b0, fetch = 1'b0, priv = 1'b0, mmu_en = 1'b0, single_vm = 1'b0;
  logic        hit = 1'b0, multi = 1'b0, dirty = 1'b0;
  logic [21:0] ppn = '0;
  logic [1:0]  size = '0, prot = '0;
  logic        use_asid, rsp_valid, pa_ok;
  logic [31:0] paddr;
  logic [11:0] exc_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mmu_xlate_chk uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .vaddr_i(vaddr),
    .write_i(write), .fetch_i(fetch), .priv_i(priv), .mmu_en_i(mmu_en),
    .single_vm_i(single_vm), .tlb_hit_i(hit), .tlb_multi_i(multi),
    .tlb_ppn_i(ppn), .tlb_size_i(size), .tlb_prot_i(prot), .tlb_dirty_i(dirty),
    .use_asid_o(use_asid), .rsp_valid_o(rsp_valid), .paddr_o(paddr),
    .exc_code_o(exc_code), .pa_ok_o(pa_ok)
  );

  localparam logic [31:0] ADDRS [11] = '{
    32'h0000_1234, 32'h7FFF_F00C, 32'h1234_5678, 32'h8000_0000, 32'hBFFF_FFFF,
    32'hC000_0000, 32'hDFFF_FFFC, 32'hE000_0000, 32'hE400_0000, 32'hE400_0001,
    32'hFFFF_FFFF};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent model built from the requirement text
  task automatic model(output logic [11:0] e, output logic ok, output logic [31:0] pa,
                       output string tag);
    logic [31:0] m;
    bit fx, fe;
    fx = (vaddr >= 32'h8000_0000 && vaddr < 32'hC000_0000) || vaddr >= 32'hE000_0000;
    fe = fetch && !write;
    m  = (32'd1 << (size == 0 ? 10 : size == 1 ? 12 : size == 2 ? 16 : 20)) - 32'd1;
    pa = vaddr & 32'h1FFF_FFFF;
    e  = 12'h000;
    if (fx) begin
      tag = "R1";
      if (!priv && !(vaddr >= 32'hE000_0000 && vaddr <= 32'hE400_0000)) begin
        tag = "R2"; e = write ? 12'h060 : 12'h040;
      end
    end else if (!mmu_en) begin
      tag = "R3";
    end else begin
      pa = ({ppn, 10'b0} & ~m) | (vaddr & m);
      if (multi) begin tag = "R5"; e = 12'h140; end
      else if (!hit) begin tag = "R6"; e = write ? 12'h060 : 12'h040; end
      else if (fe) begin tag = "R7"; if (priv && !prot[1]) e = 12'h0A0; end
      else if (!priv && !prot[1]) begin tag = "R8"; e = write ? 12'h0C0 : 12'h0A0; end
      else if (write && !prot[0]) begin tag = "R8"; e = 12'h0C0; end
      else if (write && !dirty) begin tag = "R9"; e = 12'h080; end
      else tag = "R10";
    end
    ok = (e == 12'h000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] e_exp;
    logic        ok_exp;
    logic [31:0] pa_exp;
    string       tag;

    repeat (3) @(negedge clk);
    check("R11 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R11 reset pa_ok", {31'b0, pa_ok}, 32'd0);
    check("R11 reset exc", {20'b0, exc_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 2; p++) begin
        single_vm = s[0]; priv = p[0];
        #1 check("R4 use_asid", {31'b0, use_asid}, {31'b0, (s == 0 && p == 0)});
      end
    end

    for (int ai = 0; ai < 11; ai++)
    for (int w = 0; w < 2; w++)
    for (int f = 0; f < 2; f++)
    for (int pv = 0; pv < 2; pv++)
    for (int en = 0; en < 2; en++)
    for (int pr = 0; pr < 4; pr++)
    for (int d = 0; d < 2; d++)
    for (int hk = 0; hk < 3; hk++)
    for (int sz = 0; sz < 4; sz++) begin
      vaddr = ADDRS[ai] ^ {20'b0, 4'(sz), 4'(pr), 4'(hk)};
      write = w[0]; fetch = f[0]; priv = pv[0]; mmu_en = en[0];
      prot = 2'(pr); dirty = d[0]; size = 2'(sz);
      hit = (hk == 1); multi = (hk == 2);
      ppn = 22'h2A5A5 ^ {20'b0, 2'(sz)} ^ 22'(ai << 12);
      req_valid = 1'b1;
      model(e_exp, ok_exp, pa_exp, tag);
      @(negedge clk);
      check({tag, " R11 rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
      check({tag, " exc"}, {20'b0, exc_code}, {20'b0, e_exp});
      check({tag, " pa_ok"}, {31'b0, pa_ok}, {31'b0, ok_exp});
      if (ok_exp) check({tag, " paddr"}, paddr, pa_exp);
    end

    req_valid = 1'b0;
    @(negedge clk);
    check("R11 idle rsp_valid", {31'b0, rsp_valid}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule